// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block is the host-side slave receiver for the SMBus Host Notify message. A device that has taken the master role sends this message to tell the host it needs attention. The frame is the host's slave address with the write bit, then the sender's own address, then a 16-bit status word sent low byte first. The block sits behind a byte-level slave engine. That engine reports start (including repeated start), stop and each received byte. For every byte the block answers with an acknowledge decision one cycle later.

Once the last status byte of a well-formed frame arrives, the block latches two values: the sender's 7-bit address and the status word. It then raises an interrupt request. The request holds until software pulses a clear input. While a notification is pending, further Host Notify frames are refused at the address byte, so the latched values cannot be overwritten before they are read.

Top module: `hn_notify_rx`

## Requirements
- R1: While reset is held, and after it is released with no traffic, `irq`, `ack_vld`, `ack`, `notify_addr` and `notify_status` are all zero.
- R2: The first byte after a start is the address byte. It is acknowledged (`ack_vld`=1, `ack`=1 on the cycle after `byte_valid`) only when three conditions hold: bits 7:1 equal `HOST_ADDR` (default 7'h08), bit 0 (direction) is 0, and no notification is pending.
- R3: An address byte with another address, or with bit 0 set, is answered NACK. Every further byte up to the next start is also NACK, and no interrupt follows.
- R4: After an acknowledged address, the next three bytes (sender address, status low, status high) are each acknowledged. Any byte after the third, before a stop or start, is NACK.
- R5: One cycle after the third payload byte is taken, `irq` is 1 and `notify_addr` holds bits 7:1 of the first payload byte. At the same time, `notify_status` holds the third payload byte in bits 15:8 and the second in bits 7:0.
- R6: A stop or a repeated start before the third payload byte drops the partial frame. No interrupt is raised and the latched outputs keep their previous values. A repeated start begins a new frame.
- R7: `irq` stays 1 until `irq_clr` is sampled high, and is 0 on the cycle after that.
- R8: While `irq` is 1, a matching address byte is NACKed and the latched outputs do not change. This holds even when `irq_clr` is high in the same cycle as that address byte.
- R9: When `irq_clr` is high in the same cycle as the third payload byte, the new notification wins: `irq` is 1 afterwards and holds the new values.
- R10: Every `byte_valid` gets exactly one answer on the next cycle, and no answer appears without one. A byte that coincides with a start or stop, or that arrives with no frame open, is answered NACK and dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| byte_valid | input | 1 | A received byte is on `byte_data` |
| byte_data | input | 8 | Received byte |
| irq_clr | input | 1 | Software clear of the pending notification |
| ack_vld | output | 1 | Acknowledge decision valid (one cycle after `byte_valid`) |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| irq | output | 1 | Notification pending |
| notify_addr | output | 7 | Latched address of the notifying device |
| notify_status | output | 16 | Latched status word |

## Verification
Two events can land in the same cycle: the frame commit that sets the interrupt, and the software clear that drops it. The bench provokes this in two places. First, it pulses `irq_clr` with the last status byte and expects the interrupt to stay set with the fresh word. Second, it pulses `irq_clr` with a matching address byte while a notification is pending, and expects that byte to be NACKed and the interrupt to fall. A behavioural model, built on a byte queue, predicts every output on every clock. Targeted checks confirm the latched values and the acknowledge answers at each of these points.

// File: rtl/hn_pkg.sv
`timescale 1ns/1ps
package hn_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DEV,
    ST_DATA,
    ST_DONE
  } hn_state_e;
endpackage

// File: rtl/hn_frame_fsm.sv
`timescale 1ns/1ps
module hn_frame_fsm
  import hn_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HOST_ADDR = 7'h08,
  parameter int unsigned       NB        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              pending,
  output logic              ack_vld,
  output logic              ack,
  output logic              dev_we,
  output logic [NB-1:0]     lane_we,
  output logic              commit
);
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;

  hn_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             dec_ack;
  logic             addr_hit;

  assign addr_hit = (byte_data[BYTE_W-1:1] == HOST_ADDR) && !byte_data[0] && !pending;

  // next-state and per-byte decision
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    dec_ack = 1'b0;
    dev_we  = 1'b0;
    lane_we = '0;
    commit  = 1'b0;
    if (bus_start) begin
      st_d  = ST_ADDR;
      idx_d = '0;
    end else if (bus_stop) begin
      st_d = ST_IDLE;
    end else if (byte_valid) begin
      unique case (st_q)
        ST_ADDR: begin
          if (addr_hit) begin
            dec_ack = 1'b1;
            st_d    = ST_DEV;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_DEV: begin
          dec_ack = 1'b1;
          dev_we  = 1'b1;
          idx_d   = '0;
          st_d    = ST_DATA;
        end
        ST_DATA: begin
          dec_ack = 1'b1;
          lane_we = NB'(1) << idx_q;
          if (idx_q == IDX_W'(NB - 1)) begin
            commit = 1'b1;
            st_d   = ST_DONE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
        default: dec_ack = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      ack_vld <= 1'b0;
      ack     <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      ack_vld <= byte_valid;
      ack     <= dec_ack;
    end
  end
endmodule

// File: rtl/hn_capture.sv
`timescale 1ns/1ps
module hn_capture
  import hn_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BYTE_W-1:0]    byte_data,
  input  logic                 dev_we,
  input  logic [NB-1:0]        lane_we,
  input  logic                 commit,
  output logic [ADDR_W-1:0]    notify_addr,
  output logic [NB*BYTE_W-1:0] notify_status
);
  logic [ADDR_W-1:0]    dev_stage;
  logic [NB*BYTE_W-1:0] word_stage;
  logic [NB*BYTE_W-1:0] word_next;

  // per-lane staging, lane 0 is the low byte
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign word_next[g*BYTE_W +: BYTE_W] =
      lane_we[g] ? byte_data : word_stage[g*BYTE_W +: BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_stage[g*BYTE_W +: BYTE_W] <= '0;
      end else if (lane_we[g]) begin
        word_stage[g*BYTE_W +: BYTE_W] <= byte_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_stage <= '0;
    end else if (dev_we) begin
      dev_stage <= byte_data[BYTE_W-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      notify_addr   <= '0;
      notify_status <= '0;
    end else if (commit) begin
      notify_addr   <= dev_stage;
      notify_status <= word_next;
    end
  end
endmodule

// File: rtl/hn_irq.sv
`timescale 1ns/1ps
module hn_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_en;
  logic irq_d;

  assign irq_en = set | clr;
  assign irq_d  = set;   // a set in the same cycle as a clear wins

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (irq_en) begin
      irq <= irq_d;
    end
  end
endmodule

// File: rtl/hn_notify_rx.sv
`timescale 1ns/1ps
module hn_notify_rx
  import hn_pkg::*;
#(
  parameter logic [6:0]  HOST_ADDR = 7'h08,
  parameter int unsigned WORD_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              irq_clr,
  output logic              ack_vld,
  output logic              ack,
  output logic              irq,
  output logic [6:0]        notify_addr,
  output logic [WORD_W-1:0] notify_status
);
  localparam int unsigned NB = WORD_W / BYTE_W;

  logic          dev_we_w;
  logic [NB-1:0] lane_we_w;
  logic          commit_w;

  hn_frame_fsm #(
    .HOST_ADDR (HOST_ADDR),
    .NB        (NB)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .pending    (irq),
    .ack_vld    (ack_vld),
    .ack        (ack),
    .dev_we     (dev_we_w),
    .lane_we    (lane_we_w),
    .commit     (commit_w)
  );

  hn_capture #(
    .NB (NB)
  ) u_cap (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_data     (byte_data),
    .dev_we        (dev_we_w),
    .lane_we       (lane_we_w),
    .commit        (commit_w),
    .notify_addr   (notify_addr),
    .notify_status (notify_status)
  );

  hn_irq u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (commit_w),
    .clr   (irq_clr),
    .irq   (irq)
  );
endmodule

// File: rtl/hn_notify_rx_chk.sv
`timescale 1ns/1ps
module hn_notify_rx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic              irq_clr,
  input logic              ack_vld,
  input logic              ack,
  input logic              irq,
  input logic [6:0]        notify_addr,
  input logic [WORD_W-1:0] notify_status,
  input logic              commit
);
  p_answer_each_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> ack_vld);

  p_no_stray_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> (!ack_vld && !ack));

  p_irq_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_irq_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !commit) |=> !irq);

  p_commit_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);

  p_no_commit_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !irq);

  p_latch_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> ($stable(notify_addr) && $stable(notify_status)));

  p_rise_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(byte_valid));
endmodule

bind hn_notify_rx hn_notify_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_valid    (byte_valid),
  .irq_clr       (irq_clr),
  .ack_vld       (ack_vld),
  .ack           (ack),
  .irq           (irq),
  .notify_addr   (notify_addr),
  .notify_status (notify_status),
  .commit        (commit_w)
);

// File: tb/sim_hn_notify_rx.sv
`timescale 1ns/1ps
module sim_hn_notify_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_start, bus_stop, byte_valid, irq_clr;
  logic [7:0]  byte_data;
  logic        ack_vld, ack, irq;
  logic [6:0]  notify_addr;
  logic [15:0] notify_status;

  int    total = 0;
  int    bad   = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;   // 200 MHz

  hn_notify_rx u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_start     (bus_start),
    .bus_stop      (bus_stop),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .irq_clr       (irq_clr),
    .ack_vld       (ack_vld),
    .ack           (ack),
    .irq           (irq),
    .notify_addr   (notify_addr),
    .notify_status (notify_status)
  );

  // behavioural reference model
  int         m_phase;          // 0 closed, 1 wants address, 2 collecting payload
  logic [7:0] m_q[$];
  bit         m_ackv, m_ack, m_irq;
  logic [6:0] m_addr;
  logic [15:0] m_stat;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_q.delete();
      m_ackv = 0; m_ack = 0; m_irq = 0; m_addr = '0; m_stat = '0;
    end else begin
      bit fire;
      fire   = 0;
      m_ackv = byte_valid;
      m_ack  = 0;
      if (bus_start) begin
        m_phase = 1; m_q.delete();
      end else if (bus_stop) begin
        m_phase = 0;
      end else if (byte_valid) begin
        if (m_phase == 1) begin
          if (byte_data == 8'h10 && !m_irq) begin m_ack = 1; m_phase = 2; end
          else m_phase = 0;
        end else if (m_phase == 2) begin
          m_q.push_back(byte_data);
          m_ack = 1;
          if (m_q.size() == 3) begin fire = 1; m_phase = 0; end
        end
      end
      if (fire) begin
        m_irq = 1; m_addr = m_q[0][7:1]; m_stat = {m_q[2], m_q[1]};
      end else if (irq_clr) begin
        m_irq = 0;
      end
    end
  end

  task automatic cmp(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      cmp({cur_req, " model ack_vld"}, int'(ack_vld), int'(m_ackv));
      cmp({cur_req, " model ack"},     int'(ack),     int'(m_ack));
      cmp({cur_req, " model irq"},     int'(irq),     int'(m_irq));
      cmp({cur_req, " model addr"},    int'(notify_addr),   int'(m_addr));
      cmp({cur_req, " model status"},  int'(notify_status), int'(m_stat));
    end
  end

  task automatic drv(bit s, bit p, bit v, logic [7:0] d, bit c);
    @(negedge clk);
    bus_start = s; bus_stop = p; byte_valid = v; byte_data = d; irq_clr = c;
  endtask

  task automatic quiet();
    drv(0, 0, 0, 8'h00, 0);
  endtask

  task automatic send(logic [7:0] d);
    drv(0, 0, 1, d, 0);
    quiet();
  endtask

  // called one negedge after a byte cycle: answer is visible now
  task automatic chk_ans(string req, bit exp_ack);
    cmp({req, " answer"}, int'({ack_vld, ack}), exp_ack ? 3 : 2);
  endtask

  task automatic chk_note(string req, bit e_irq, logic [6:0] e_addr, logic [15:0] e_stat);
    cmp({req, " irq"},    int'(irq),           int'(e_irq));
    cmp({req, " addr"},   int'(notify_addr),   int'(e_addr));
    cmp({req, " status"}, int'(notify_status), int'(e_stat));
  endtask

  initial begin
    rst_n = 0; bus_start = 0; bus_stop = 0; byte_valid = 0; byte_data = 0; irq_clr = 0;
    repeat (3) @(negedge clk);
    cmp("R1 reset ack_vld", int'(ack_vld), 0);
    chk_note("R1 reset", 0, 7'h00, 16'h0000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk_note("R1 after release", 0, 7'h00, 16'h0000);

    // R2 R4 R5: full frame from device 0x35, status 0x1234
    cur_req = "R2";
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h10); chk_ans("R2 host address", 1);
    cur_req = "R4";
    send(8'h6A); chk_ans("R4 device byte", 1);
    send(8'h34); chk_ans("R4 low byte", 1);
    send(8'h12); chk_ans("R4 high byte", 1);
    cur_req = "R5";
    chk_note("R5 latched", 1, 7'h35, 16'h1234);
    send(8'h55); chk_ans("R4 surplus byte", 0);
    drv(0, 1, 0, 0, 0); quiet();

    // R7: held while not cleared
    cur_req = "R7";
    repeat (8) @(negedge clk);
    cmp("R7 irq held", int'(irq), 1);

    // R8: pending refuses a new frame
    cur_req = "R8";
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h10); chk_ans("R8 pending address", 0);
    send(8'h44); chk_ans("R8 byte after refusal", 0);
    send(8'h01); send(8'h02);
    chk_note("R8 unchanged", 1, 7'h35, 16'h1234);
    drv(0, 1, 0, 0, 0); quiet();
    // clear in the same cycle as a matching address byte
    drv(1, 0, 0, 0, 0); quiet();
    drv(0, 0, 1, 8'h10, 1); quiet();
    chk_ans("R8 clear with address", 0);
    cmp("R7 cleared", int'(irq), 0);
    cmp("R8 data kept after clear", int'(notify_status), 16'h1234);
    drv(0, 1, 0, 0, 0); quiet();

    // R3: foreign address and read direction
    cur_req = "R3";
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h22); chk_ans("R3 foreign address", 0);
    send(8'h10); chk_ans("R3 later byte", 0);
    send(8'h66); send(8'h77);
    cmp("R3 no irq", int'(irq), 0);
    drv(0, 1, 0, 0, 0); quiet();
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h11); chk_ans("R3 read direction", 0);
    drv(0, 1, 0, 0, 0); quiet();

    // R6: stop mid-frame, then repeated start mid-frame
    cur_req = "R6";
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h10); send(8'h20); send(8'h99);
    drv(0, 1, 0, 0, 0); quiet();
    chk_note("R6 stop discards", 0, 7'h35, 16'h1234);
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h10); send(8'h20);
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h10); chk_ans("R6 address after repeated start", 1);
    send(8'h42); send(8'hCD);
    cmp("R6 no irq yet", int'(irq), 0);
    send(8'hAB);
    chk_note("R6 new frame", 1, 7'h21, 16'hABCD);
    drv(0, 1, 0, 0, 0); quiet();
    drv(0, 0, 0, 0, 1); quiet();
    cmp("R7 clear pulse", int'(irq), 0);

    // R9: clear coincides with the completing byte
    cur_req = "R9";
    drv(1, 0, 0, 0, 0); quiet();
    send(8'h10); send(8'h0E); send(8'h01);
    drv(0, 0, 1, 8'h02, 1); quiet();
    chk_ans("R9 high byte", 1);
    chk_note("R9 set wins", 1, 7'h07, 16'h0201);
    drv(0, 1, 0, 0, 0); quiet();
    drv(0, 0, 0, 0, 1); quiet();

    // R10: bytes with start/stop, and with no frame open
    cur_req = "R10";
    drv(1, 0, 1, 8'h10, 0); quiet();
    chk_ans("R10 byte with start", 0);
    send(8'h10); chk_ans("R10 address after start", 1);
    drv(0, 1, 1, 8'h6A, 0); quiet();
    chk_ans("R10 byte with stop", 0);
    send(8'h10); chk_ans("R10 byte with no frame", 0);
    repeat (3) @(negedge clk);
    cmp("R10 no stray answer", int'(ack_vld), 0);
    cmp("R10 no irq", int'(irq), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule